// File: doc/BRIEF.md
# Twelve-Bit Sliced ALU Datapath with Register File

This block is the arithmetic datapath of a small microcoded processor. It is built as a row of identical 4-bit slices whose carries ripple from the least significant slice to the most significant one. With the default parameters it forms a 12-bit word. The slices share an eight-entry register file with two read ports, and a separate Q working register.

Every cycle the microcode supplies a 9-bit operation made of three 3-bit fields. The source field picks the two ALU operands, R and S. Each operand comes from the register file, from Q, from the external data input, or is zero. The function field picks one of three arithmetic operations or one of five logic operations. The destination field says where the result F goes. It can go to Q, to the register addressed by the B port, or nowhere. Some destination codes store F shifted by one place, and some also shift Q by one place.

The data output, the carry out and the flags are combinational from the current operands. The register file and Q change only on the rising clock edge.

Top module: `bslice_dp`

## Requirements
- R1: The source field selects the operands (R, S) as follows: 0 = (A, Q), 1 = (A, B), 2 = (0, Q), 3 = (0, B), 4 = (0, A), 5 = (D, A), 6 = (D, Q), 7 = (D, 0). Here A and B are the registers addressed by `i_a_sel` and `i_b_sel`, and D is `i_din`.
- R2: The arithmetic function codes compute, modulo 2^12 with the carry out taken from bit 12:
  - function 0 computes F = R + S + cin;
  - function 1 computes F = S + ~R + cin;
  - function 2 computes F = R + ~S + cin.
- R3: The logic function codes compute F bitwise, with `o_cout` = 0:
  - 3 = R | S;
  - 4 = R & S;
  - 5 = ~R & S;
  - 6 = R ^ S;
  - 7 = ~(R ^ S).
- R4: A carry generated in a lower slice propagates through all higher slices. For example, 0xFFF + 0 + 1 gives F = 0 and `o_cout` = 1.
- R5: `o_zero` is 1 exactly when all 12 bits of F are 0.
- R6: `o_sign` equals bit 11 of F.
- R7: Destination 0 loads Q with F on the clock edge and drives F on `o_y`.
- R8: Destination 1 changes neither the register file nor Q, and drives F on `o_y`.
- R9: Destination 2 writes F to register B and drives the current value of register A, not F, on `o_y`.
- R10: Destination 3 writes F to register B and drives F on `o_y`. A written value is read back unchanged through either read port.
- R11: Destinations 4 and 5 write F shifted right by one place into register B, with 0 entering bit 11. Destination 4 also shifts Q right by one place, with 0 entering bit 11.
- R12: Destinations 6 and 7 write F shifted left by one place into register B, with 0 entering bit 0. Destination 6 also shifts Q left by one place, with 0 entering bit 0.
- R13: An active-low reset clears all register-file entries and Q to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of register file and Q |
| i_src | input | 3 | Operand source field |
| i_fn | input | 3 | ALU function field |
| i_dst | input | 3 | Result destination field |
| i_a_sel | input | 3 | Read address of port A |
| i_b_sel | input | 3 | Read and write address of port B |
| i_din | input | 12 | External data operand D |
| i_cin | input | 1 | Carry into the lowest slice |
| o_y | output | 12 | Data output (F, or register A for destination 2) |
| o_cout | output | 1 | Carry out of the highest slice |
| o_zero | output | 1 | Result-is-zero flag |
| o_sign | output | 1 | Most significant result bit |

## Verification
The assertions take for granted the following input conditions outside reset:
- every opcode field, port select and carry-in holds a known value at each rising edge;
- the operation presented in a cycle is the one whose result is stored at the following edge.

The stimulus meets these conditions by driving every input from the falling edge, including during reset, where it holds a no-write destination. Because every 3-bit field value is a legal code, the random phase may draw freely over all of them without leaving the defined input space.

// File: rtl/bslice_pkg.sv
package bslice_pkg;

   typedef enum logic [2:0] {
      SRC_AQ = 3'd0,
      SRC_AB = 3'd1,
      SRC_ZQ = 3'd2,
      SRC_ZB = 3'd3,
      SRC_ZA = 3'd4,
      SRC_DA = 3'd5,
      SRC_DQ = 3'd6,
      SRC_DZ = 3'd7
   } src_e;

   typedef enum logic [2:0] {
      FN_ADD   = 3'd0,
      FN_SMR   = 3'd1,
      FN_RMS   = 3'd2,
      FN_OR    = 3'd3,
      FN_AND   = 3'd4,
      FN_NANDS = 3'd5,
      FN_XOR   = 3'd6,
      FN_XNOR  = 3'd7
   } fn_e;

   typedef enum logic [2:0] {
      DST_LDQ    = 3'd0,
      DST_NONE   = 3'd1,
      DST_WR_A   = 3'd2,
      DST_WR     = 3'd3,
      DST_SHR_BQ = 3'd4,
      DST_SHR_B  = 3'd5,
      DST_SHL_BQ = 3'd6,
      DST_SHL_B  = 3'd7
   } dst_e;

endpackage

// File: rtl/bslice_unit.sv
module bslice_unit
   import bslice_pkg::*;
#(
   parameter int SLICE_W = 4
) (
   input  logic [SLICE_W-1:0] r_in,
   input  logic [SLICE_W-1:0] s_in,
   input  logic [2:0]         fn,
   input  logic               c_in,
   output logic [SLICE_W-1:0] f_out,
   output logic               c_out
);

   logic [SLICE_W:0] sum;
   logic [SLICE_W:0] cext;

   assign cext = {{SLICE_W{1'b0}}, c_in};

   always_comb begin
      sum = '0;
      unique case (fn_e'(fn))
         FN_ADD:   sum = {1'b0, r_in}  + {1'b0, s_in}  + cext;
         FN_SMR:   sum = {1'b0, ~r_in} + {1'b0, s_in}  + cext;
         FN_RMS:   sum = {1'b0, r_in}  + {1'b0, ~s_in} + cext;
         FN_OR:    sum = {1'b0, r_in | s_in};
         FN_AND:   sum = {1'b0, r_in & s_in};
         FN_NANDS: sum = {1'b0, ~r_in & s_in};
         FN_XOR:   sum = {1'b0, r_in ^ s_in};
         FN_XNOR:  sum = {1'b0, ~(r_in ^ s_in)};
         default:  sum = '0;
      endcase
   end

   assign f_out = sum[SLICE_W-1:0];
   assign c_out = sum[SLICE_W];

endmodule

// File: rtl/bslice_regs.sv
module bslice_regs #(
   parameter int W      = 12,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_we,
   input  logic [W-1:0]      b_wdata,
   input  logic              q_we,
   input  logic [W-1:0]      q_wdata,
   output logic [W-1:0]      a_data,
   output logic [W-1:0]      b_data,
   output logic [W-1:0]      q_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [W-1:0] mem [DEPTH];
   logic [W-1:0] q_reg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            mem[k] <= '0;
         end
      end else if (b_we) begin
         mem[b_addr] <= b_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_reg <= '0;
      end else if (q_we) begin
         q_reg <= q_wdata;
      end
   end

   assign a_data = mem[a_addr];
   assign b_data = mem[b_addr];
   assign q_data = q_reg;

endmodule

// File: rtl/bslice_dp.sv
module bslice_dp
   import bslice_pkg::*;
#(
   parameter int SLICE_W  = 4,
   parameter int N_SLICES = 3,
   parameter int ADDR_W   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [2:0]                  i_src,
   input  logic [2:0]                  i_fn,
   input  logic [2:0]                  i_dst,
   input  logic [ADDR_W-1:0]           i_a_sel,
   input  logic [ADDR_W-1:0]           i_b_sel,
   input  logic [SLICE_W*N_SLICES-1:0] i_din,
   input  logic                        i_cin,
   output logic [SLICE_W*N_SLICES-1:0] o_y,
   output logic                        o_cout,
   output logic                        o_zero,
   output logic                        o_sign
);

   localparam int W = SLICE_W * N_SLICES;

   if (SLICE_W < 1) begin : g_bad_slice
      $error("bslice_dp: SLICE_W must be at least 1");
   end
   if (N_SLICES < 1) begin : g_bad_count
      $error("bslice_dp: N_SLICES must be at least 1");
   end
   if (W < 2) begin : g_bad_width
      $error("bslice_dp: word must be at least 2 bits for shifting");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("bslice_dp: ADDR_W out of range");
   end

   logic [W-1:0]      a_val;
   logic [W-1:0]      b_val;
   logic [W-1:0]      q_cur;
   logic [W-1:0]      r_op;
   logic [W-1:0]      s_op;
   logic [W-1:0]      alu_f;
   logic [N_SLICES:0] carry;
   logic              rf_we;
   logic [W-1:0]      rf_wd;
   logic              q_we;
   logic [W-1:0]      q_wd;

   // operand selection
   always_comb begin
      r_op = '0;
      s_op = '0;
      unique case (src_e'(i_src))
         SRC_AQ: begin r_op = a_val; s_op = q_cur; end
         SRC_AB: begin r_op = a_val; s_op = b_val; end
         SRC_ZQ: begin r_op = '0;    s_op = q_cur; end
         SRC_ZB: begin r_op = '0;    s_op = b_val; end
         SRC_ZA: begin r_op = '0;    s_op = a_val; end
         SRC_DA: begin r_op = i_din; s_op = a_val; end
         SRC_DQ: begin r_op = i_din; s_op = q_cur; end
         SRC_DZ: begin r_op = i_din; s_op = '0;    end
         default: begin r_op = '0;   s_op = '0;    end
      endcase
   end

   // slice row with rippled carry
   assign carry[0] = i_cin;

   for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
      bslice_unit #(
         .SLICE_W (SLICE_W)
      ) u_unit (
         .r_in  (r_op[g*SLICE_W +: SLICE_W]),
         .s_in  (s_op[g*SLICE_W +: SLICE_W]),
         .fn    (i_fn),
         .c_in  (carry[g]),
         .f_out (alu_f[g*SLICE_W +: SLICE_W]),
         .c_out (carry[g+1])
      );
   end

   // destination decode
   always_comb begin
      rf_we = 1'b0;
      rf_wd = alu_f;
      q_we  = 1'b0;
      q_wd  = alu_f;
      unique case (dst_e'(i_dst))
         DST_LDQ: begin
            q_we = 1'b1;
         end
         DST_NONE: begin
         end
         DST_WR_A, DST_WR: begin
            rf_we = 1'b1;
         end
         DST_SHR_BQ: begin
            rf_we = 1'b1;
            rf_wd = {1'b0, alu_f[W-1:1]};
            q_we  = 1'b1;
            q_wd  = {1'b0, q_cur[W-1:1]};
         end
         DST_SHR_B: begin
            rf_we = 1'b1;
            rf_wd = {1'b0, alu_f[W-1:1]};
         end
         DST_SHL_BQ: begin
            rf_we = 1'b1;
            rf_wd = {alu_f[W-2:0], 1'b0};
            q_we  = 1'b1;
            q_wd  = {q_cur[W-2:0], 1'b0};
         end
         DST_SHL_B: begin
            rf_we = 1'b1;
            rf_wd = {alu_f[W-2:0], 1'b0};
         end
         default: begin
         end
      endcase
   end

   bslice_regs #(
      .W      (W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_addr  (i_a_sel),
      .b_addr  (i_b_sel),
      .b_we    (rf_we),
      .b_wdata (rf_wd),
      .q_we    (q_we),
      .q_wdata (q_wd),
      .a_data  (a_val),
      .b_data  (b_val),
      .q_data  (q_cur)
   );

   assign o_y    = (dst_e'(i_dst) == DST_WR_A) ? a_val : alu_f;
   assign o_cout = carry[N_SLICES];
   assign o_zero = (alu_f == '0);
   assign o_sign = alu_f[W-1];

endmodule

// File: rtl/bslice_dp_chk.sv
module bslice_dp_chk #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   i_fn,
   input logic [2:0]   i_dst,
   input logic [W-1:0] o_y,
   input logic         o_cout,
   input logic         o_zero,
   input logic         o_sign,
   input logic [W-1:0] alu_f,
   input logic [W-1:0] q_cur
);

   // R5
   a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (i_dst != 3'd2) |-> (o_zero == (o_y == '0)));

   // R6
   a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (i_dst != 3'd2) |-> (o_sign == o_y[W-1]));

   // R3
   a_r3_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (i_fn >= 3'd3) |-> !o_cout);

   // R7
   a_r7_q_load: assert property (@(posedge clk) disable iff (!rst_n)
      (i_dst == 3'd0) |=> (q_cur == $past(alu_f)));

   // R11
   a_r11_q_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
      (i_dst == 3'd4) |=> (q_cur == {1'b0, $past(q_cur[W-1:1])}));

   // R12
   a_r12_q_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
      (i_dst == 3'd6) |=> (q_cur == {$past(q_cur[W-2:0]), 1'b0}));

   // R8
   a_r8_q_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (i_dst == 3'd1 || i_dst == 3'd2 || i_dst == 3'd3 || i_dst == 3'd5 || i_dst == 3'd7)
      |=> $stable(q_cur));

endmodule

bind bslice_dp bslice_dp_chk #(
   .W (SLICE_W * N_SLICES)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .i_fn   (i_fn),
   .i_dst  (i_dst),
   .o_y    (o_y),
   .o_cout (o_cout),
   .o_zero (o_zero),
   .o_sign (o_sign),
   .alu_f  (alu_f),
   .q_cur  (q_cur)
);

// File: tb/test_bslice_dp.sv
`timescale 1ns/1ps
module test_bslice_dp;

   localparam int W  = 12;
   localparam int NR = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    i_src, i_fn, i_dst, i_a_sel, i_b_sel;
   logic [W-1:0]  i_din;
   logic          i_cin;
   logic [W-1:0]  o_y;
   logic          o_cout, o_zero, o_sign;

   always #2.5 clk = ~clk;

   bslice_dp i_bslice_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .i_src   (i_src),
      .i_fn    (i_fn),
      .i_dst   (i_dst),
      .i_a_sel (i_a_sel),
      .i_b_sel (i_b_sel),
      .i_din   (i_din),
      .i_cin   (i_cin),
      .o_y     (o_y),
      .o_cout  (o_cout),
      .o_zero  (o_zero),
      .o_sign  (o_sign)
   );

   typedef struct {
      logic [W-1:0] y;
      logic         co;
      logic         z;
      logic         s;
      string        tag;
   } exp_t;

   exp_t         sbq [$];
   int           n_vec = 0;
   int           n_bad = 0;
   bit           done  = 1'b0;
   logic [W-1:0] mrf [NR];
   logic [W-1:0] mq;

   // driver: drives one operation at the falling edge, pushes its expected result
   // and advances the reference storage to the state after the next rising edge
   task automatic apply(input logic [2:0] src, input logic [2:0] fn, input logic [2:0] dst,
                        input logic [2:0] a, input logic [2:0] b, input logic [W-1:0] d,
                        input logic ci, input string tag);
      logic [W-1:0] av, bv, r, s, f;
      logic [W:0]   t;
      exp_t         e;
      av = mrf[a];
      bv = mrf[b];
      case (src)
         3'd0: begin r = av; s = mq; end
         3'd1: begin r = av; s = bv; end
         3'd2: begin r = '0; s = mq; end
         3'd3: begin r = '0; s = bv; end
         3'd4: begin r = '0; s = av; end
         3'd5: begin r = d;  s = av; end
         3'd6: begin r = d;  s = mq; end
         default: begin r = d; s = '0; end
      endcase
      case (fn)
         3'd0: t = {1'b0, r} + {1'b0, s} + {{W{1'b0}}, ci};
         3'd1: t = {1'b0, s} + {1'b0, ~r} + {{W{1'b0}}, ci};
         3'd2: t = {1'b0, r} + {1'b0, ~s} + {{W{1'b0}}, ci};
         3'd3: t = {1'b0, r | s};
         3'd4: t = {1'b0, r & s};
         3'd5: t = {1'b0, ~r & s};
         3'd6: t = {1'b0, r ^ s};
         default: t = {1'b0, ~(r ^ s)};
      endcase
      f = t[W-1:0];
      @(negedge clk);
      i_src = src; i_fn = fn; i_dst = dst; i_a_sel = a; i_b_sel = b;
      i_din = d; i_cin = ci;
      e.y   = (dst == 3'd2) ? av : f;
      e.co  = t[W];
      e.z   = (f == '0);
      e.s   = f[W-1];
      e.tag = tag;
      sbq.push_back(e);
      case (dst)
         3'd0: mq = f;
         3'd2, 3'd3: mrf[b] = f;
         3'd4: begin mrf[b] = {1'b0, f[W-1:1]}; mq = {1'b0, mq[W-1:1]}; end
         3'd5: mrf[b] = {1'b0, f[W-1:1]};
         3'd6: begin mrf[b] = {f[W-2:0], 1'b0}; mq = {mq[W-2:0], 1'b0}; end
         3'd7: mrf[b] = {f[W-2:0], 1'b0};
         default: ;
      endcase
   endtask

   task automatic drain();
      while (sbq.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      i_src = 3'd7; i_fn = 3'd3; i_dst = 3'd1; i_a_sel = '0; i_b_sel = '0;
      i_din = '0; i_cin = 1'b0;
   endtask

   // monitor: compares outputs 1 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_vec++;
            if (o_y !== e.y || o_cout !== e.co || o_zero !== e.z || o_sign !== e.s) begin
               n_bad++;
               $display("FAIL %s: y=%h cout=%b zero=%b sign=%b expected y=%h cout=%b zero=%b sign=%b",
                        e.tag, o_y, o_cout, o_zero, o_sign, e.y, e.co, e.z, e.s);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      string tags [8];
      tags = '{"R7", "R8", "R9", "R10", "R11", "R11", "R12", "R12"};
      for (int i = 0; i < NR; i++) mrf[i] = '0;
      mq = '0;
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R13: reset state of every register and Q
      for (int i = 0; i < NR; i++) apply(3'd4, 3'd3, 3'd1, i[2:0], 3'd0, '0, 1'b0, "R13");
      apply(3'd2, 3'd3, 3'd1, 3'd0, 3'd0, '0, 1'b0, "R13");

      // R10: fill the register file, read back through both ports
      for (int i = 0; i < NR; i++)
         apply(3'd7, 3'd3, 3'd3, 3'd0, i[2:0], 12'h111 * (i + 1) + 12'h005, 1'b0, "R10");
      for (int i = 0; i < NR; i++) apply(3'd4, 3'd3, 3'd1, i[2:0], 3'd0, '0, 1'b0, "R10");
      for (int i = 0; i < NR; i++) apply(3'd3, 3'd3, 3'd1, 3'd0, i[2:0], '0, 1'b0, "R10");

      // R7: load Q and read it back
      apply(3'd7, 3'd3, 3'd0, 3'd0, 3'd0, 12'h3C3, 1'b0, "R7");
      apply(3'd2, 3'd3, 3'd1, 3'd0, 3'd0, '0, 1'b0, "R7");

      // R1: every source selection with an add
      for (int sidx = 0; sidx < 8; sidx++)
         apply(sidx[2:0], 3'd0, 3'd1, 3'd1, 3'd2, 12'h0A5, 1'b0, "R1");

      // R2: subtractions and add with both carry-in values
      for (int fidx = 0; fidx < 3; fidx++) begin
         apply(3'd1, fidx[2:0], 3'd1, 3'd3, 3'd5, '0, 1'b0, "R2");
         apply(3'd1, fidx[2:0], 3'd1, 3'd3, 3'd5, '0, 1'b1, "R2");
         apply(3'd1, fidx[2:0], 3'd1, 3'd5, 3'd3, '0, 1'b1, "R2");
      end

      // R3: logic functions
      for (int fidx = 3; fidx < 8; fidx++) begin
         apply(3'd5, fidx[2:0], 3'd1, 3'd4, 3'd0, 12'hF0C, 1'b1, "R3");
         apply(3'd1, fidx[2:0], 3'd1, 3'd6, 3'd7, '0, 1'b0, "R3");
      end

      // R4: full ripple and a mid-word carry
      apply(3'd7, 3'd0, 3'd1, 3'd0, 3'd0, 12'hFFF, 1'b1, "R4");
      apply(3'd7, 3'd0, 3'd1, 3'd0, 3'd0, 12'h0FF, 1'b1, "R4");
      apply(3'd7, 3'd0, 3'd1, 3'd0, 3'd0, 12'h00F, 1'b1, "R4");

      // R5: equal operands subtract to zero
      apply(3'd1, 3'd2, 3'd1, 3'd2, 3'd2, '0, 1'b1, "R5");
      apply(3'd7, 3'd3, 3'd1, 3'd0, 3'd0, 12'h000, 1'b0, "R5");
      // R6: sign set and clear
      apply(3'd7, 3'd3, 3'd1, 3'd0, 3'd0, 12'h800, 1'b0, "R6");
      apply(3'd7, 3'd3, 3'd1, 3'd0, 3'd0, 12'h7FF, 1'b0, "R6");

      // R8: no write, then register and Q unchanged
      apply(3'd7, 3'd3, 3'd1, 3'd0, 3'd2, 12'hABC, 1'b0, "R8");
      apply(3'd3, 3'd3, 3'd1, 3'd0, 3'd2, '0, 1'b0, "R8");
      apply(3'd2, 3'd3, 3'd1, 3'd0, 3'd0, '0, 1'b0, "R8");

      // R9: write with A passed to the output
      apply(3'd7, 3'd3, 3'd2, 3'd1, 3'd6, 12'h5A5, 1'b0, "R9");
      apply(3'd4, 3'd3, 3'd1, 3'd6, 3'd0, '0, 1'b0, "R9");

      // R11: right shifts
      apply(3'd7, 3'd3, 3'd0, 3'd0, 3'd0, 12'h801, 1'b0, "R11");
      apply(3'd7, 3'd3, 3'd4, 3'd0, 3'd3, 12'hF03, 1'b0, "R11");
      apply(3'd4, 3'd3, 3'd1, 3'd3, 3'd0, '0, 1'b0, "R11");
      apply(3'd2, 3'd3, 3'd1, 3'd0, 3'd0, '0, 1'b0, "R11");
      apply(3'd7, 3'd3, 3'd5, 3'd0, 3'd4, 12'h00F, 1'b0, "R11");
      apply(3'd4, 3'd3, 3'd1, 3'd4, 3'd0, '0, 1'b0, "R11");
      apply(3'd2, 3'd3, 3'd1, 3'd0, 3'd0, '0, 1'b0, "R11");

      // R12: left shifts
      apply(3'd7, 3'd3, 3'd0, 3'd0, 3'd0, 12'h801, 1'b0, "R12");
      apply(3'd7, 3'd3, 3'd6, 3'd0, 3'd5, 12'h8F1, 1'b0, "R12");
      apply(3'd4, 3'd3, 3'd1, 3'd5, 3'd0, '0, 1'b0, "R12");
      apply(3'd2, 3'd3, 3'd1, 3'd0, 3'd0, '0, 1'b0, "R12");
      apply(3'd7, 3'd3, 3'd7, 3'd0, 3'd1, 12'hC00, 1'b0, "R12");
      apply(3'd4, 3'd3, 3'd1, 3'd1, 3'd0, '0, 1'b0, "R12");
      apply(3'd2, 3'd3, 3'd1, 3'd0, 3'd0, '0, 1'b0, "R12");

      // mixed random operations
      for (int n = 0; n < 400; n++) begin
         logic [2:0] rd;
         rd = 3'($urandom_range(0, 7));
         apply(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), rd,
               3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
               12'($urandom), 1'($urandom), tags[rd]);
      end

      // R13: reset after the file holds data
      drain();
      rst_n = 1'b0;
      idle_inputs();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NR; i++) mrf[i] = '0;
      mq = '0;
      for (int i = 0; i < NR; i++) apply(3'd4, 3'd3, 3'd1, i[2:0], 3'd0, '0, 1'b0, "R13");
      apply(3'd2, 3'd3, 3'd1, 3'd0, 3'd0, '0, 1'b0, "R13");

      drain();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule